// File: doc/BRIEF.md
# Supply Monitor Reset Sequencer

This block turns a supply-good comparator flag into a clean system reset. The flag arrives asynchronously from an analog comparator and is brought into the clock domain with two flip-flops. While the flag reports a low supply, the reset output is held active. When the supply returns, the reset is released only after the flag has stayed high without a break for a fixed hold time. That hold time is a parameter counted in clock cycles. For silicon it is 250 ms times the clock frequency; simulation uses a small value.

An asynchronous power-on input forces the reset active as soon as power is applied. A communication-abort output follows the reset. It ends any serial transfer in progress and blocks new commands. The busy flag of a nonvolatile write passes straight through the block. Reset never touches it, so a write that has already started runs to completion.

Top module: `supply_reset_seq`

## Requirements
- R1: While `por_n` is low, `rst_out` is high at once, without waiting for a clock edge. After `por_n` rises, the supply flag must pass through the synchronizer and complete the full hold interval before reset is released.
- R2: If `supply_ok` is sampled low, `rst_out` is high after the second rising clock edge that follows, and it stays high for as long as the flag stays low.
- R3: Number the rising edges from the first edge after `supply_ok` rises and then stays high. `rst_out` stays high through edge HOLD_CYCLES+1 and goes low after edge HOLD_CYCLES+2.
- R4: If the synchronizer captures a low `supply_ok` during the hold interval, the hold count is cleared. The release then comes HOLD_CYCLES+2 edges after the flag rises again.
- R5: `comm_abort` equals `rst_out` in every cycle.
- R6: `wr_busy_out` equals `wr_busy_in` in every cycle, whether or not reset is active. Toggling `wr_busy_in` does not change when reset is released.
- R7: Once reset has been released, `rst_out` stays low for as long as `supply_ok` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Comparator flag (asynchronous): supply is above the trip level |
| wr_busy_in | input | 1 | Busy flag of a nonvolatile write in progress |
| rst_out | output | 1 | System reset, active high |
| comm_abort | output | 1 | Ends the serial transfer in progress and blocks new commands |
| wr_busy_out | output | 1 | Write-busy flag passed through unchanged |

## Verification
Reset activity and write-busy activity can coincide: a nonvolatile write can be busy in the same cycle that reset is asserted, and again in the cycle it is released. The bench toggles `wr_busy_in` during a supply drop and during the hold interval that follows. In every cycle it requires `wr_busy_out` to track the input while `comm_abort` tracks the reset. It also requires the release edge to fall on exactly the same cycle as in a run without busy activity.

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
  parameter int HOLD_CYCLES = 12_500_000
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok,
  input  logic wr_busy_in,
  output logic rst_out,
  output logic comm_abort,
  output logic wr_busy_out
);

  localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [1:0]       sync_q;
  logic             ok_s;
  logic             rst_q;
  logic [CNT_W-1:0] cnt;

  assign ok_s = sync_q[1];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], supply_ok};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_q <= 1'b1;
      cnt   <= '0;
    end else if (!ok_s) begin
      rst_q <= 1'b1;
      cnt   <= '0;
    end else if (rst_q) begin
      if (cnt == LAST) rst_q <= 1'b0;
      else             cnt   <= cnt + 1'b1;
    end
  end

  assign rst_out     = rst_q | ~ok_s | ~por_n;
  assign comm_abort  = rst_out;
  assign wr_busy_out = wr_busy_in;

  // Independent run-length of good synchronized samples, used only by checks
  logic [CNT_W:0] ok_run;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                               ok_run <= '0;
    else if (!ok_s)                           ok_run <= '0;
    else if (ok_run != (CNT_W+1)'(HOLD_CYCLES)) ok_run <= ok_run + 1'b1;
  end

  assert_drop_sets_reset_R2: assert property (@(posedge clk) disable iff (!por_n)
    !ok_s |=> rst_q);

  assert_release_after_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_q) |-> ok_run >= (CNT_W+1)'(HOLD_CYCLES));

  assert_rise_keeps_reset_R4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ok_s) |=> rst_out);

  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!por_n)
    cnt <= LAST);

  assert_stays_released_R7: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_q && ok_s) |=> !rst_q);

endmodule

// File: tb/supply_reset_seq_tb.sv
module supply_reset_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic supply_ok = 1'b0;
  logic wr_busy_in = 1'b0;
  logic rst_out, comm_abort, wr_busy_out;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_reset_seq #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .wr_busy_in(wr_busy_in),
    .rst_out(rst_out), .comm_abort(comm_abort), .wr_busy_out(wr_busy_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic side_checks();
    check("R5 abort", comm_abort, rst_out);
    check("R6 busy", wr_busy_out, wr_busy_in);
  endtask

  // Supply flag has just risen at a negedge; walk HOLD+2 edges (R3)
  task automatic expect_release(input string req, input bit toggle_busy);
    for (int n = 1; n <= HOLD + 2; n++) begin
      if (toggle_busy) wr_busy_in = ~wr_busy_in;
      @(negedge clk);
      side_checks();
      if (n == HOLD + 1 || n == HOLD + 2 || n == 1)
        check(req, rst_out, (n < HOLD + 2) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic t_reset_state();
    #1;
    check("R1 por reset", rst_out, 1'b1);
    check("R5 por abort", comm_abort, 1'b1);
    repeat (3) @(negedge clk);
    check("R1 por held", rst_out, 1'b1);
  endtask

  task automatic t_power_up();
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 supply low keeps reset", rst_out, 1'b1);
    supply_ok = 1'b1;
    expect_release("R3 release timing", 1'b0);
    repeat (20) @(negedge clk);
    check("R7 stays released", rst_out, 1'b0);
    side_checks();
  endtask

  task automatic t_drop(input bit busy);
    wr_busy_in = busy;
    supply_ok = 1'b0;
    @(negedge clk);
    check("R2 one edge after drop", rst_out, 1'b0);
    side_checks();
    @(negedge clk);
    check("R2 two edges after drop", rst_out, 1'b1);
    side_checks();
    repeat (HOLD + 5) @(negedge clk);
    check("R2 held while low", rst_out, 1'b1);
    supply_ok = 1'b1;
    expect_release("R3 release after drop", busy);
  endtask

  task automatic t_dip();
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    repeat (HOLD - 2) @(negedge clk);
    check("R4 still in hold", rst_out, 1'b1);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    expect_release("R4 restart after dip", 1'b0);
  endtask

  task automatic t_busy_overlap();
    wr_busy_in = 1'b1;
    supply_ok = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 busy during reset", wr_busy_out, 1'b1);
    check("R5 abort during reset", comm_abort, 1'b1);
    supply_ok = 1'b1;
    expect_release("R6 busy does not shift release", 1'b1);
    wr_busy_in = 1'b0;
    #1;
    check("R6 busy clears after release", wr_busy_out, 1'b0);
  endtask

  task automatic t_por_midway();
    @(negedge clk);
    por_n = 1'b0;
    #1;
    check("R1 async assert", rst_out, 1'b1);
    check("R5 abort on por", comm_abort, 1'b1);
    @(negedge clk);
    por_n = 1'b1;
    expect_release("R1 full hold after por", 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_power_up();
    t_drop(1'b0);
    t_dip();
    t_busy_overlap();
    t_por_midway();
    t_drop(1'b1);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule